// File: doc/BRIEF.md
# Prioritized Event Controller

This block decides, between instructions, whether a small processor core should leave its current flow and enter a handler. It serves sixteen priority levels, where a lower number means higher priority. Level 0 is emulation, 1 is reset, 2 is the non-maskable interrupt, 3 is the exception level, and 4 is not an event at all: its bit in the in-service vector is the global interrupt disable. Level 5 is hardware error and levels 6 to 15 are general interrupts. The block keeps three 16-bit vectors. The latched vector holds requests that have been seen. The enable mask gates the maskable levels. The in-service vector records the levels being served, and its lowest set bit, ignoring bit 4, is the current level. When no level bit is set the core is in user mode, which ranks below every level.

Raise requests arrive as a bit vector and are always latched. The instruction sequencer can also pulse a re-check, which lets a request that was latched earlier enter once priorities allow. When an event is taken, the controller holds the redirect strobe for one cycle. With the strobe it presents the handler address, a one-hot choice of which return register to load, and the return address to put there. It also pulses a stack-swap strobe when the entry leaves user mode. The datapath uses that strobe to save the user stack pointer, load the kernel one and force bit 0 of the loop-bottom registers. An exception-class request that arrives while the core is already at that priority or higher is a double fault. A double fault halts the controller until reset.

The controller is a three-state machine. IDLE evaluates requests. ENTER lasts exactly one cycle and drives the redirect outputs. HALT is entered on a double fault and left only by reset. The transitions are: IDLE to ENTER on a taken event, IDLE to HALT on a double fault, ENTER back to IDLE always, and HALT to itself.

Top module: `evt_ctrl`

## Requirements
- R1: After reset the latched vector is 0x0000, the enable mask is 0x001F and the in-service vector is 0x0002. Redirect, stack swap and double fault are all low.
- R2: Every bit of `raise_vld` is set in the latched vector, whatever the state. Only the lowest-numbered raised level is evaluated in that cycle, and the others stay latched.
- R3: A taken event clears its latched bit and sets its in-service bit. Redirect goes high in the cycle after the request and stays high for exactly one cycle.
- R4: Levels 0 and 1 are always taken. Level 0 selects the emulation return register (`ret_sel` = 4'b1000) with the current PC. Level 1 selects no return register (4'b0000, return address 0).
- R5: A request for level 2 or 3 while the current level number is less than or equal to it is a double fault. `dbl_fault` goes high the next cycle and stays high until reset, `fault_cause` reads 0x3F, and no further redirect occurs.
- R6: A request for level 5 to 15 is not taken when its enable bit is clear, or when in-service bit 4 is set and the core is not in user mode. Its latched bit stays set.
- R7: Level 5 to 15 enters only when it has a lower number than the current level, or the same number with `self_nest_en` high. It selects the interrupt return register (4'b0001). The return address is the current PC, with bit 0 set when the level equals the current level.
- R8: Level 3 selects the exception return register (4'b0010). Its return address is the current PC when `exc_cause` is 0x20 or more, and `next_pc` otherwise. Level 2 selects the NMI return register (4'b0100) with the current PC.
- R9: The handler address is vector table entry 1 when the level is 7 or higher and its `ovr_mask` bit is set. Otherwise it is the level's own table entry, and override bits below 7 have no effect.
- R10: Entering any level from 5 to 15 also sets in-service bit 4.
- R11: A re-check is ignored while in-service bit 4 is set or while any raise bit is high. Otherwise it evaluates the lowest-numbered bit of latched AND enable under the rules of R7.
- R12: `kstack_swap` pulses together with redirect when the in-service vector had no level bit set (bit 4 aside) before the entry.
- R13: A raise of level 4 sets latched bit 4 but never causes an entry.
- R14: Bus writes with `cfg_we` high go to address 0 to 15 for the vector table, 16 for the enable mask (low 16 bits) and 17 for the in-service vector. The in-service write is used by the return sequencer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| raise_vld | input | 16 | Raise request per level |
| recheck | input | 1 | Instruction-boundary re-check of latched requests |
| self_nest_en | input | 1 | Allow re-entry of the current level |
| cur_pc | input | 32 | Address of the instruction about to run |
| next_pc | input | 32 | Address of the instruction after it |
| exc_cause | input | 6 | Exception cause code |
| ovr_mask | input | 16 | Vector override per level (honoured from level 7) |
| cfg_we | input | 1 | Register bus write strobe |
| cfg_addr | input | 5 | Register bus address |
| cfg_wdata | input | 32 | Register bus write data |
| redirect | output | 1 | One-cycle PC redirect strobe |
| target_pc | output | 32 | Handler address |
| ret_sel | output | 4 | One-hot return register select: bit0 interrupt, bit1 exception, bit2 NMI, bit3 emulation |
| ret_addr | output | 32 | Value for the selected return register |
| kstack_swap | output | 1 | User-to-supervisor stack swap strobe |
| dbl_fault | output | 1 | Double fault halt flag |
| fault_cause | output | 6 | Cause code, 0x3F while halted |
| latched | output | 16 | Latched request vector |
| enabled | output | 16 | Enable mask |
| active | output | 16 | In-service vector |

## Verification
The assertions check on every cycle that the return select is never multi-hot and that redirect never lasts longer than one cycle. They also check that a double fault is sticky, stops all redirects and reports cause 0x3F, that an interrupt-class entry leaves the global disable set, and that the stack swap only appears with a redirect. The bench scenarios show what depends on history and configuration. These include the choice between the current and next PC for exceptions, the self-nesting bit in the return address, override and mask blocking, and re-checks that the disable bit suppresses. They also include which of several simultaneous requests wins.

// File: rtl/evc_pkg.sv
package evc_pkg;

    localparam int LVL_EMU     = 0;
    localparam int LVL_RST     = 1;
    localparam int LVL_NMI     = 2;
    localparam int LVL_EXC     = 3;
    localparam int LVL_GDIS    = 4;
    localparam int LVL_HWE     = 5;
    localparam int LVL_OVR_MIN = 7;

    localparam int CAUSE_W = 6;
    localparam logic [CAUSE_W-1:0] CAUSE_DBL       = 6'h3F;
    localparam logic [CAUSE_W-1:0] CAUSE_SVC_LIMIT = 6'h20;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ENTER = 2'd1,
        ST_HALT  = 2'd2
    } evc_state_e;

    typedef enum logic [3:0] {
        RS_NONE = 4'b0000,
        RS_RETI = 4'b0001,
        RS_RETX = 4'b0010,
        RS_RETN = 4'b0100,
        RS_RETE = 4'b1000
    } ret_sel_e;

endpackage

// File: rtl/evc_prio.sv
module evc_prio #(
    parameter int W  = 16,
    parameter int IW = 5
) (
    input  logic [W-1:0]  req,
    output logic [IW-1:0] idx,
    output logic          any
);
    // lowest-numbered set bit wins; idx = W when nothing is set
    always_comb begin
        idx = IW'(W);
        any = 1'b0;
        for (int i = W - 1; i >= 0; i--) begin
            if (req[i]) begin
                idx = IW'(i);
                any = 1'b1;
            end
        end
    end
endmodule

// File: rtl/evc_vectab.sv
module evc_vectab #(
    parameter int NLVL = 16,
    parameter int AW   = 32,
    parameter int IW   = 5,
    localparam int LW  = $clog2(NLVL)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [IW-1:0] waddr,
    input  logic [AW-1:0] wdata,
    input  logic [LW-1:0] rd_idx,
    output logic [AW-1:0] rd_vec,
    output logic [AW-1:0] rst_vec
);
    logic [AW-1:0] ent_w [NLVL];

    for (genvar g = 0; g < NLVL; g++) begin : g_ent
        logic [AW-1:0] ent_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                ent_q <= '0;
            else if (we && waddr == IW'(g))
                ent_q <= wdata;
        end
        assign ent_w[g] = ent_q;
    end

    assign rd_vec  = ent_w[rd_idx];
    assign rst_vec = ent_w[evc_pkg::LVL_RST];
endmodule

// File: rtl/evt_ctrl.sv
module evt_ctrl
    import evc_pkg::*;
#(
    parameter int NLVL = 16,
    parameter int AW   = 32,
    localparam int LW  = $clog2(NLVL),
    localparam int IW  = LW + 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NLVL-1:0]     raise_vld,
    input  logic                recheck,
    input  logic                self_nest_en,
    input  logic [AW-1:0]       cur_pc,
    input  logic [AW-1:0]       next_pc,
    input  logic [CAUSE_W-1:0]  exc_cause,
    input  logic [NLVL-1:0]     ovr_mask,
    input  logic                cfg_we,
    input  logic [IW-1:0]       cfg_addr,
    input  logic [AW-1:0]       cfg_wdata,
    output logic                redirect,
    output logic [AW-1:0]       target_pc,
    output logic [3:0]          ret_sel,
    output logic [AW-1:0]       ret_addr,
    output logic                kstack_swap,
    output logic                dbl_fault,
    output logic [CAUSE_W-1:0]  fault_cause,
    output logic [NLVL-1:0]     latched,
    output logic [NLVL-1:0]     enabled,
    output logic [NLVL-1:0]     active
);
    localparam logic [IW-1:0]   ADDR_ENA   = IW'(NLVL);
    localparam logic [IW-1:0]   ADDR_ACT   = IW'(NLVL + 1);
    localparam logic [NLVL-1:0] ENA_RESET  = NLVL'(5'h1F);
    localparam logic [NLVL-1:0] ACT_RESET  = NLVL'(1) << LVL_RST;
    localparam logic [NLVL-1:0] GDIS_BIT   = NLVL'(1) << LVL_GDIS;

    evc_state_e state_q, state_d;

    logic [NLVL-1:0] latch_q, enable_q, act_q;
    logic [AW-1:0]   target_q, ret_q;
    logic [3:0]      sel_q;
    logic            swap_q;

    // priority resolution
    logic [IW-1:0] cur_lvl, raise_lvl, pend_lvl, cand_lvl;
    logic          cur_any, raise_any, pend_any, cand_vld;
    logic          gdis, user_mode, nest_ok, take, dbl;
    logic [LW-1:0] cand_idx;

    evc_prio #(.W(NLVL), .IW(IW)) u_cur (
        .req (act_q & ~GDIS_BIT),
        .idx (cur_lvl),
        .any (cur_any)
    );

    evc_prio #(.W(NLVL), .IW(IW)) u_raise (
        .req (raise_vld),
        .idx (raise_lvl),
        .any (raise_any)
    );

    evc_prio #(.W(NLVL), .IW(IW)) u_pend (
        .req (latch_q & enable_q),
        .idx (pend_lvl),
        .any (pend_any)
    );

    assign gdis      = act_q[LVL_GDIS];
    assign user_mode = !cur_any;

    always_comb begin
        cand_vld = 1'b0;
        cand_lvl = raise_lvl;
        if (raise_any) begin
            cand_vld = 1'b1;
        end else if (recheck && !gdis && pend_any) begin
            cand_vld = 1'b1;
            cand_lvl = pend_lvl;
        end
    end

    assign cand_idx = cand_lvl[LW-1:0];
    assign nest_ok  = (cand_lvl < cur_lvl) || (self_nest_en && cand_lvl == cur_lvl);

    // admission rules by event class
    always_comb begin
        take = 1'b0;
        dbl  = 1'b0;
        if (cand_vld && state_q == ST_IDLE) begin
            if (cand_lvl <= IW'(LVL_RST)) begin
                take = 1'b1;
            end else if (cand_lvl <= IW'(LVL_EXC)) begin
                if (cur_lvl <= cand_lvl) dbl = 1'b1;
                else                     take = 1'b1;
            end else if (cand_lvl == IW'(LVL_GDIS)) begin
                take = 1'b0;
            end else if ((gdis && !user_mode) || !enable_q[cand_idx]) begin
                take = 1'b0;
            end else begin
                take = nest_ok;
            end
        end
    end

    // return register choice and handler address
    logic [AW-1:0] rd_vec, rst_vec, target_d, ret_d;
    logic [3:0]    sel_d;

    evc_vectab #(.NLVL(NLVL), .AW(AW), .IW(IW)) u_vtab (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (cfg_we),
        .waddr   (cfg_addr),
        .wdata   (cfg_wdata),
        .rd_idx  (cand_idx),
        .rd_vec  (rd_vec),
        .rst_vec (rst_vec)
    );

    always_comb begin
        unique case (cand_lvl)
            IW'(LVL_EMU): begin sel_d = RS_RETE; ret_d = cur_pc; end
            IW'(LVL_RST): begin sel_d = RS_NONE; ret_d = '0;     end
            IW'(LVL_NMI): begin sel_d = RS_RETN; ret_d = cur_pc; end
            IW'(LVL_EXC): begin
                sel_d = RS_RETX;
                ret_d = (exc_cause >= CAUSE_SVC_LIMIT) ? cur_pc : next_pc;
            end
            default: begin
                sel_d = RS_RETI;
                ret_d = cur_pc | AW'(cand_lvl == cur_lvl);
            end
        endcase
        if (cand_lvl >= IW'(LVL_OVR_MIN) && ovr_mask[cand_idx])
            target_d = rst_vec;
        else
            target_d = rd_vec;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (dbl) state_d = ST_HALT;
                      else if (take) state_d = ST_ENTER;
            ST_ENTER: state_d = ST_IDLE;
            ST_HALT:  state_d = ST_HALT;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // event vectors
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            latch_q  <= '0;
            enable_q <= ENA_RESET;
            act_q    <= ACT_RESET;
        end else begin
            latch_q <= (latch_q | raise_vld) & ~((NLVL'(take)) << cand_idx);
            if (cfg_we && cfg_addr == ADDR_ENA)
                enable_q <= cfg_wdata[NLVL-1:0];
            if (cfg_we && cfg_addr == ADDR_ACT)
                act_q <= cfg_wdata[NLVL-1:0];
            else if (take)
                act_q <= act_q | (NLVL'(1) << cand_idx)
                               | ((cand_lvl >= IW'(LVL_HWE)) ? GDIS_BIT : '0);
        end
    end

    // entry output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            target_q <= '0;
            ret_q    <= '0;
            sel_q    <= RS_NONE;
            swap_q   <= 1'b0;
        end else if (take) begin
            target_q <= target_d;
            ret_q    <= ret_d;
            sel_q    <= sel_d;
            swap_q   <= user_mode;
        end
    end

    assign redirect    = (state_q == ST_ENTER);
    assign target_pc   = target_q;
    assign ret_sel     = redirect ? sel_q : RS_NONE;
    assign ret_addr    = ret_q;
    assign kstack_swap = redirect && swap_q;
    assign dbl_fault   = (state_q == ST_HALT);
    assign fault_cause = dbl_fault ? CAUSE_DBL : '0;
    assign latched     = latch_q;
    assign enabled     = enable_q;
    assign active      = act_q;

endmodule

// File: rtl/evt_ctrl_chk.sv
module evt_ctrl_chk #(
    parameter int NLVL = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            redirect,
    input logic [3:0]      ret_sel,
    input logic            kstack_swap,
    input logic            dbl_fault,
    input logic [5:0]      fault_cause,
    input logic [NLVL-1:0] active
);
    AST_RET_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ret_sel)); // R4

    AST_REDIRECT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |=> !redirect); // R3

    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        dbl_fault |=> (dbl_fault && !redirect)); // R5

    AST_FAULT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        dbl_fault |-> (fault_cause == 6'h3F)); // R5

    AST_GDIS_ON_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect && ret_sel == 4'b0001) |-> active[4]); // R10

    AST_SWAP_WITH_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
        kstack_swap |-> redirect); // R12

    AST_NO_FAULT_AND_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        !(dbl_fault && redirect)); // R5
endmodule

bind evt_ctrl evt_ctrl_chk #(.NLVL(NLVL)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .redirect    (redirect),
    .ret_sel     (ret_sel),
    .kstack_swap (kstack_swap),
    .dbl_fault   (dbl_fault),
    .fault_cause (fault_cause),
    .active      (active)
);

// File: tb/evt_ctrl_test.sv
module evt_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] raise_vld = '0;
    logic        recheck = 1'b0;
    logic        self_nest_en = 1'b0;
    logic [31:0] cur_pc = 32'h0;
    logic [31:0] next_pc;
    logic [5:0]  exc_cause = '0;
    logic [15:0] ovr_mask = '0;
    logic        cfg_we = 1'b0;
    logic [4:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        redirect, kstack_swap, dbl_fault;
    logic [31:0] target_pc, ret_addr;
    logic [3:0]  ret_sel;
    logic [5:0]  fault_cause;
    logic [15:0] latched, enabled, active;

    always #10 clk = ~clk;   // 50 MHz
    always_comb next_pc = cur_pc + 32'd4;

    evt_ctrl uut (
        .clk(clk), .rst_n(rst_n), .raise_vld(raise_vld), .recheck(recheck),
        .self_nest_en(self_nest_en), .cur_pc(cur_pc), .next_pc(next_pc),
        .exc_cause(exc_cause), .ovr_mask(ovr_mask), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .redirect(redirect),
        .target_pc(target_pc), .ret_sel(ret_sel), .ret_addr(ret_addr),
        .kstack_swap(kstack_swap), .dbl_fault(dbl_fault),
        .fault_cause(fault_cause), .latched(latched), .enabled(enabled),
        .active(active)
    );

    typedef struct {
        logic [31:0] tgt;
        logic [3:0]  sel;
        logic [31:0] ret;
        logic        swp;
        string       req;
    } exp_t;

    exp_t exp_q[$];
    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 1'b0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // driver side of the scoreboard
    task automatic expect_entry(input logic [31:0] tgt, input logic [3:0] sel,
                                input logic [31:0] ret, input logic swp, input string req);
        exp_t e;
        e.tgt = tgt; e.sel = sel; e.ret = ret; e.swp = swp; e.req = req;
        exp_q.push_back(e);
    endtask

    // monitor side of the scoreboard
    always @(negedge clk) begin
        exp_t e;
        if (rst_n && redirect) begin
            if (exp_q.size() == 0) begin
                check("R3 unexpected redirect", 32'd1, 32'd0);
            end else begin
                e = exp_q.pop_front();
                check({e.req, " target"}, target_pc, e.tgt);
                check({e.req, " ret_sel"}, {28'd0, ret_sel}, {28'd0, e.sel});
                check({e.req, " ret_addr"}, ret_addr, e.ret);
                check("R12 stack swap", {31'd0, kstack_swap}, {31'd0, e.swp});
            end
        end
    end

    task automatic bus_wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic raise(input logic [15:0] m);
        @(negedge clk);
        raise_vld = m;
        @(negedge clk);
        raise_vld = '0;
        @(negedge clk);
        check("R3 strobe one cycle", {31'd0, redirect}, 32'd0);
    endtask

    task automatic do_recheck();
        @(negedge clk);
        recheck = 1'b1;
        @(negedge clk);
        recheck = 1'b0;
        @(negedge clk);
        check("R3 strobe one cycle", {31'd0, redirect}, 32'd0);
    endtask

    task automatic check_reset_state();
        check("R1 latched", {16'd0, latched}, 32'h0000);
        check("R1 enabled", {16'd0, enabled}, 32'h001F);
        check("R1 active", {16'd0, active}, 32'h0002);
        check("R1 redirect", {31'd0, redirect}, 32'd0);
        check("R1 dbl_fault", {31'd0, dbl_fault}, 32'd0);
    endtask

    function automatic logic [31:0] vec(input int i);
        return 32'h1000 + 32'(i) * 32'h100;
    endfunction

    task automatic finish_run();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_reset_state();

        // R14: configure table, mask, in-service
        for (int i = 0; i < 16; i++) bus_wr(5'(i), vec(i));
        bus_wr(5'd16, 32'h0000FFFF);
        check("R14 enable write", {16'd0, enabled}, 32'hFFFF);
        bus_wr(5'd17, 32'h0);
        check("R14 active write", {16'd0, active}, 32'h0);

        // R7, R10, R12: general level from user mode
        cur_pc = 32'h200;
        expect_entry(vec(6), 4'b0001, 32'h200, 1'b1, "R7 enter 6");
        raise(16'h0040);
        check("R10 gdis set", {16'd0, active}, 32'h0050);
        check("R3 latch cleared", {31'd0, latched[6]}, 32'd0);

        // R6: blocked by global disable while not in user mode
        raise(16'h0200);
        check("R6 gdis block latched", {31'd0, latched[9]}, 32'd1);
        check("R6 gdis block active", {16'd0, active}, 32'h0050);

        // R6: blocked by mask bit from user mode
        bus_wr(5'd17, 32'h0);
        bus_wr(5'd16, 32'h0000EFEF);
        raise(16'h1000);
        check("R6 mask block latched", {31'd0, latched[12]}, 32'd1);
        check("R6 mask block active", {16'd0, active}, 32'h0);

        // R13: level 4 raise only latches
        raise(16'h0010);
        check("R13 latched", {31'd0, latched[4]}, 32'd1);
        check("R13 active", {16'd0, active}, 32'h0);

        // R11: re-check with lower priority than current does nothing
        bus_wr(5'd17, 32'h0040);
        do_recheck();
        check("R11 not higher", {31'd0, latched[9]}, 32'd1);
        bus_wr(5'd17, 32'h0400);
        cur_pc = 32'h300;
        expect_entry(vec(9), 4'b0001, 32'h300, 1'b0, "R11 recheck 9");
        do_recheck();
        check("R11 active", {16'd0, active}, 32'h0610);

        // R11: re-check ignored while global disable set
        bus_wr(5'd17, 32'h0410);
        raise(16'h0100);
        do_recheck();
        check("R11 gdis ignore", {31'd0, latched[8]}, 32'd1);
        bus_wr(5'd17, 32'h0400);
        expect_entry(vec(8), 4'b0001, 32'h300, 1'b0, "R11 recheck 8");
        do_recheck();

        // R7: self nesting
        bus_wr(5'd17, 32'h0040);
        raise(16'h0040);
        check("R7 no self nest", {31'd0, latched[6]}, 32'd1);
        self_nest_en = 1'b1;
        cur_pc = 32'h400;
        expect_entry(vec(6), 4'b0001, 32'h401, 1'b0, "R7 self nest");
        raise(16'h0040);
        self_nest_en = 1'b0;

        // R9: vector override
        bus_wr(5'd17, 32'h0);
        ovr_mask = 16'h0100;
        cur_pc = 32'h500;
        expect_entry(vec(1), 4'b0001, 32'h500, 1'b1, "R9 override 8");
        raise(16'h0100);
        bus_wr(5'd17, 32'h0);
        ovr_mask = 16'h0040;
        expect_entry(vec(6), 4'b0001, 32'h500, 1'b1, "R9 low override ignored");
        raise(16'h0040);
        ovr_mask = 16'h0;

        // R2: simultaneous raises
        bus_wr(5'd17, 32'h0);
        expect_entry(vec(9), 4'b0001, 32'h500, 1'b1, "R2 lowest wins");
        raise(16'h0A00);
        check("R2 other latched", {31'd0, latched[11]}, 32'd1);

        // R8: exception return address by cause, NMI
        bus_wr(5'd17, 32'h0040);
        exc_cause = 6'h21;
        cur_pc = 32'h600;
        expect_entry(vec(3), 4'b0010, 32'h600, 1'b0, "R8 exc high cause");
        raise(16'h0008);
        bus_wr(5'd17, 32'h0040);
        exc_cause = 6'h05;
        expect_entry(vec(3), 4'b0010, 32'h604, 1'b0, "R8 exc low cause");
        raise(16'h0008);
        bus_wr(5'd17, 32'h0040);
        expect_entry(vec(2), 4'b0100, 32'h600, 1'b0, "R8 nmi");
        raise(16'h0004);

        // R4: emulation and reset always taken
        expect_entry(vec(0), 4'b1000, 32'h600, 1'b0, "R4 emulation");
        raise(16'h0001);
        expect_entry(vec(1), 4'b0000, 32'h0, 1'b0, "R4 reset level");
        raise(16'h0002);

        // R5: double fault
        bus_wr(5'd17, 32'h0008);
        raise(16'h0008);
        check("R5 dbl_fault", {31'd0, dbl_fault}, 32'd1);
        check("R5 cause", {26'd0, fault_cause}, 32'h3F);
        raise(16'h0001);
        check("R5 sticky", {31'd0, dbl_fault}, 32'd1);

        // R1: reset again
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_reset_state();

        check("R3 scoreboard drained", 32'(exp_q.size()), 32'd0);
        finish_run();
    end
endmodule